// File: doc/BRIEF.md
# Serial Flash Sector Write Guard

This unit keeps the configuration word of a small serial flash device and decides, for each sector write the command logic presents, whether the array may be written. Software-visible state is a 16-bit word of which the low nine bits are implemented: a four-bit protection size code, a direction bit, a read-edge select bit, two bits for the function of the hold/ready pin (stored only), and one further stored bit with no function. The upper seven bits are reserved and always read back as zero.

The protected region is a run of 32-sector blocks that grows either upward from sector 0 or downward from the last sector of the device. The size code is decoded into one of four protection modes held in a small state register: OPEN (nothing protected), BOTTOM (region anchored at sector 0), TOP (region anchored at the last sector) and FULL (every sector protected). A configuration write moves the unit to the mode that the newly written code and direction select (transitions to_open, to_bottom, to_top, to_full). Without a write the mode holds. The write-protect pin, when driven low, overrides everything and blocks all writes. The read-edge bit is brought out directly so the serializer can launch read data on the selected clock edge.

The sector count is a parameter: 512, 1024 or 2048 sectors.

Top module: `sf_wp_cfg`

## Requirements
- R1: After reset the configuration reads 0x0009: size code 0, direction 1, read edge 0 (falling), pin-function bits 01, so every sector is writable while the pin is high.
- R2: Bits 15 to 9 always read as zero, whatever value was written to them.
- R3: A strobed write stores data bits 8 to 0 on the clock edge that samples the strobe. The read port shows the new value from then on, and it holds when no strobe is given.
- R4: Field positions in the word: bits 7 to 4 size code, bit 3 direction (0 means anchored at sector 0, 1 means anchored at the last sector), bit 2 read edge, bits 1 to 0 pin function, bit 8 stored without function.
- R5: Size code 0 protects no sector and size code 15 protects every sector.
- R6: Size code n from 1 to 14 protects n·32 sectors, limited to the device size.
- R7: With direction 0 the protected sectors are 0 up to n·32−1. With direction 1 they are the last n·32 sectors, ending at sector NUM_SECTORS−1.
- R8: While the write-protect pin is low, the permit output is low for every sector and every code.
- R9: The permit output is high only while a sector write request is present, and it follows the request, sector and pin in the same cycle with no register between them.
- R10: The read-edge output equals the stored bit 2: 1 selects the rising edge and 0 the falling edge.
- R11: The mode register changes only on a configuration write: code 0 gives OPEN, code 15 gives FULL, any other code gives BOTTOM or TOP according to the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current configuration word, reserved bits zero |
| wp_n | input | 1 | Write-protect pin level, low blocks all writes |
| sec_wr_req | input | 1 | Sector write request |
| sec_idx | input | log2(NUM_SECTORS) | Sector index of the request |
| wr_permit | output | 1 | Sector write allowed |
| rd_edge_rise | output | 1 | 1 launches read data on the rising edge, 0 on the falling edge |

## Verification
Every size code is tried in both directions, and for each one the sectors on either side of the region edge are requested, together with sector 0, the last sector and the ends of the first and last block. This separates an off-by-one block limit from a reversed direction and from a size decoded in the wrong unit. Each configuration is also tried with the pin low and with no request, which shows that the pin gate and the request gate act apart from the range. Written words carry junk in the reserved bits and vary the edge and pin-function bits, which exposes masking and field-position faults. A long random stream of writes, pin levels and sector indices is then compared with a behavioural model on every cycle.

// File: rtl/sf_wp_pkg.sv
package sf_wp_pkg;

    localparam int CFG_W     = 16;
    localparam int IMPL_W    = 9;
    localparam int BLK_SECT  = 32;
    localparam int BLK_SH    = 5;

    // Protection mode held by the mode register (R11)
    typedef enum logic [1:0] {
        MODE_OPEN   = 2'd0,
        MODE_BOTTOM = 2'd1,
        MODE_TOP    = 2'd2,
        MODE_FULL   = 2'd3
    } wp_mode_e;

    // Implemented configuration bits, MSB first (R4)
    typedef struct packed {
        logic       spare;
        logic [3:0] size_code;
        logic       dir_top;
        logic       rce;
        logic [1:0] pin_func;
    } cfg_t;

    localparam cfg_t CFG_RST = '{spare: 1'b0, size_code: 4'd0, dir_top: 1'b1,
                                 rce: 1'b0, pin_func: 2'b01};

endpackage

// File: rtl/sf_wp_cfg_reg.sv
module sf_wp_cfg_reg
    import sf_wp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q,
    output cfg_t             cfg_d,
    output logic [CFG_W-1:0] rdata
);

    localparam int RSVD_W = CFG_W - IMPL_W;

    // Reserved bits are dropped at the write (R2)
    always_comb begin
        if (we) cfg_d = cfg_t'(wdata[IMPL_W-1:0]);
        else    cfg_d = cfg_q;
    end

    // R3: new value visible after the sampling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign rdata = {{RSVD_W{1'b0}}, cfg_q};

endmodule

// File: rtl/sf_wp_mode_fsm.sv
module sf_wp_mode_fsm
    import sf_wp_pkg::*;
#(
    parameter int NUM_BLOCKS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cfg_t     cfg_d,
    output wp_mode_e mode_q
);

    wp_mode_e mode_d;

    // Transition decode: to_open, to_full, to_bottom, to_top (R11)
    always_comb begin
        unique case (cfg_d.size_code)
            4'd0:    mode_d = MODE_OPEN;
            4'd15:   mode_d = MODE_FULL;
            default: begin
                if (int'(cfg_d.size_code) >= NUM_BLOCKS) mode_d = MODE_FULL;
                else if (cfg_d.dir_top)                  mode_d = MODE_TOP;
                else                                     mode_d = MODE_BOTTOM;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_OPEN;
        else        mode_q <= mode_d;
    end

endmodule

// File: rtl/sf_wp_range_cmp.sv
module sf_wp_range_cmp
    import sf_wp_pkg::*;
#(
    parameter int NUM_SECTORS = 512
) (
    input  wp_mode_e                           mode,
    input  logic [3:0]                         size_code,
    input  logic [$clog2(NUM_SECTORS)-1:0]     sec_idx,
    output logic                               prot_hit
);

    localparam int SEC_W  = $clog2(NUM_SECTORS);
    localparam int BIDX_W = SEC_W - BLK_SH;
    localparam int CNT_W  = BIDX_W + 1;
    localparam int NBLK   = NUM_SECTORS / BLK_SECT;

    logic [CNT_W-1:0] blk;
    logic [CNT_W-1:0] nb;
    logic [CNT_W-1:0] top_start;

    assign blk       = {1'b0, sec_idx[SEC_W-1:BLK_SH]};
    assign nb        = {{(CNT_W-4){1'b0}}, size_code};
    assign top_start = CNT_W'(NBLK) - nb;

    // Output process: region membership per mode (R5, R6, R7)
    always_comb begin
        unique case (mode)
            MODE_OPEN:   prot_hit = 1'b0;
            MODE_BOTTOM: prot_hit = (blk < nb);
            MODE_TOP:    prot_hit = (blk >= top_start);
            MODE_FULL:   prot_hit = 1'b1;
            default:     prot_hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/sf_wp_cfg.sv
module sf_wp_cfg
    import sf_wp_pkg::*;
#(
    parameter int NUM_SECTORS = 512
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [15:0]                    cfg_wdata,
    output logic [15:0]                    cfg_rdata,
    input  logic                           wp_n,
    input  logic                           sec_wr_req,
    input  logic [$clog2(NUM_SECTORS)-1:0] sec_idx,
    output logic                           wr_permit,
    output logic                           rd_edge_rise
);

    localparam int NBLK = NUM_SECTORS / BLK_SECT;

    cfg_t     cfg_q;
    cfg_t     cfg_d;
    wp_mode_e mode_q;
    logic     prot_hit;

    sf_wp_cfg_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q),
        .cfg_d (cfg_d),
        .rdata (cfg_rdata)
    );

    sf_wp_mode_fsm #(.NUM_BLOCKS(NBLK)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_d  (cfg_d),
        .mode_q (mode_q)
    );

    sf_wp_range_cmp #(.NUM_SECTORS(NUM_SECTORS)) u_cmp (
        .mode      (mode_q),
        .size_code (cfg_q.size_code),
        .sec_idx   (sec_idx),
        .prot_hit  (prot_hit)
    );

    // R8, R9: pin and request gates, combinational
    always_comb begin
        wr_permit    = sec_wr_req & wp_n & ~prot_hit;
        rd_edge_rise = cfg_q.rce;   // R10
    end

endmodule

// File: rtl/sf_wp_cfg_chk.sv
module sf_wp_cfg_chk #(
    parameter int NUM_SECTORS = 512
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic [15:0]                    cfg_wdata,
    input logic [15:0]                    cfg_rdata,
    input logic                           wp_n,
    input logic                           sec_wr_req,
    input logic [$clog2(NUM_SECTORS)-1:0] sec_idx,
    input logic                           wr_permit,
    input logic                           rd_edge_rise
);

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[15:9] == 7'd0);

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata[8:0] == $past(cfg_wdata[8:0]));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7:4] == 4'd15 |-> !wr_permit);

    p_open_allows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7:4] == 4'd0 && wp_n && sec_wr_req) |-> wr_permit);

    p_bottom_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7:4] != 4'd0 && !cfg_rdata[3] && sec_idx == '0) |-> !wr_permit);

    p_top_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7:4] != 4'd0 && cfg_rdata[3] && (&sec_idx)) |-> !wr_permit);

    p_pin_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |-> !wr_permit);

    p_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_wr_req |-> !wr_permit);

    p_edge_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> rd_edge_rise == $past(cfg_wdata[2]));

endmodule

bind sf_wp_cfg sf_wp_cfg_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .wp_n         (wp_n),
    .sec_wr_req   (sec_wr_req),
    .sec_idx      (sec_idx),
    .wr_permit    (wr_permit),
    .rd_edge_rise (rd_edge_rise)
);

// File: tb/sf_wp_cfg_bench.sv
`timescale 1ns/1ps
module sf_wp_cfg_bench;

    localparam int NSEC  = 512;
    localparam int SEC_W = $clog2(NSEC);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [15:0]      cfg_wdata = '0;
    logic [15:0]      cfg_rdata;
    logic             wp_n = 1'b1;
    logic             sec_wr_req = 1'b0;
    logic [SEC_W-1:0] sec_idx = '0;
    logic             wr_permit;
    logic             rd_edge_rise;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int model_cfg = 'h009;

    always #2 clk = ~clk;

    sf_wp_cfg #(.NUM_SECTORS(NSEC)) u_sf_wp_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .wp_n         (wp_n),
        .sec_wr_req   (sec_wr_req),
        .sec_idx      (sec_idx),
        .wr_permit    (wr_permit),
        .rd_edge_rise (rd_edge_rise)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit model_permit(int cfg, int sec, bit wp, bit req);
        int code = (cfg >> 4) & 15;
        int dir  = (cfg >> 3) & 1;
        int nsec;
        bit prot;
        if (!req || !wp) return 1'b0;
        nsec = (code == 15) ? NSEC : code * 32;
        if (nsec > NSEC) nsec = NSEC;
        prot = (dir == 0) ? (sec < nsec) : (sec >= NSEC - nsec);
        return !prot;
    endfunction

    function automatic string permit_tag(int cfg, bit wp, bit req);
        int code = (cfg >> 4) & 15;
        if (!wp)                    return "R8";
        if (!req)                   return "R9";
        if (code == 0 || code == 15) return "R5";
        return "R6/R7";
    endfunction

    // One cycle: drive after falling edge, compare, then let the rising edge update the model
    task automatic step(bit we, int wd, bit wp, bit req, int sec);
        @(negedge clk);
        cfg_we     = we;
        cfg_wdata  = 16'(wd);
        wp_n       = wp;
        sec_wr_req = req;
        sec_idx    = SEC_W'(sec);
        #1;
        chk("R3/R4 rdata", int'(cfg_rdata[8:0]), model_cfg);
        chk("R2 reserved", int'(cfg_rdata[15:9]), 0);
        chk("R10 edge", int'(rd_edge_rise), (model_cfg >> 2) & 1);
        chk(permit_tag(model_cfg, wp, req), int'(wr_permit),
            int'(model_permit(model_cfg, sec, wp, req)));
        @(posedge clk);
        if (we) model_cfg = wd & 'h1FF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=0x1 expected=0x0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int sl[10];
        #3;
        // R1: reset word, open mode, falling edge
        chk("R1 reset word", int'(cfg_rdata), 'h0009);
        chk("R1 reset edge", int'(rd_edge_rise), 0);
        sec_wr_req = 1'b1;
        sec_idx    = SEC_W'(NSEC - 1);
        #1;
        chk("R1 reset permit", int'(wr_permit), 1);
        sec_wr_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Directed sweep over direction and size code (R5, R6, R7, R11)
        for (int dir = 0; dir < 2; dir++) begin
            for (int code = 0; code < 16; code++) begin
                int wd = (code << 4) | (dir << 3) | ((code & 1) << 2) | (code & 3);
                if (code & 1) wd |= 'hFE00;        // R2: junk in reserved bits
                if (code & 2) wd |= 'h100;         // R4: spare bit
                step(1'b1, wd, 1'b1, 1'b0, 0);
                sl[0] = 0;                sl[1] = 31;
                sl[2] = 32;               sl[3] = code * 32 - 1;
                sl[4] = code * 32;        sl[5] = NSEC - code * 32 - 1;
                sl[6] = NSEC - code * 32; sl[7] = NSEC - 33;
                sl[8] = NSEC - 32;        sl[9] = NSEC - 1;
                foreach (sl[i]) begin
                    int s = sl[i];
                    if (s < 0) s = 0;
                    if (s > NSEC - 1) s = NSEC - 1;
                    step(1'b0, 0, 1'b1, 1'b1, s);
                end
                step(1'b0, 0, 1'b0, 1'b1, NSEC / 2);   // R8
                step(1'b0, 0, 1'b1, 1'b0, NSEC / 2);   // R9
            end
        end

        // Random stream against the model (R3, R8, R9, R10, R11)
        for (int n = 0; n < 3000; n++) begin
            bit we  = ($urandom_range(0, 7) == 0);
            int wd  = int'($urandom_range(0, 65535));
            bit wp  = ($urandom_range(0, 5) != 0);
            bit req = ($urandom_range(0, 3) != 0);
            int sec = int'($urandom_range(0, NSEC - 1));
            step(we, wd, wp, req, sec);
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule